// File: doc/BRIEF.md
# LPC Bus Transaction Monitor

A passive observer for a Low-Pin-Count bus. It samples the four-bit multiplexed nibble bus and the active-low frame strobe on every rising bus clock edge, and it never drives the bus. It tracks each host cycle through its phases: start code, cycle type, address, the first bus turnaround, the wait/ready handshake, the data byte and the final turnaround. When a cycle completes, it reports the start code, the cycle type, the address and the data byte.

Only I/O and memory reads and writes are tracked. The address is 16 bits for I/O and 32 bits for memory, and it arrives high nibble first. The data byte arrives low nibble first. It comes before the first turnaround on a write and after the ready handshake on a read. Protocol violations set bits in a warning vector. The vector collects bits over one cycle, is reported with the result, and stays readable at the port until the next cycle begins. DMA, firmware-memory, bus-master and sideband traffic is not reported.

Top module: `lpc_txn_monitor`

## Requirements
- R1: While the frame strobe is high in the idle state, nibble values have no effect: `txn_valid` stays 0 and the warnings stay 0.
- R2: While the frame strobe stays low for several clocks, the start code kept is the nibble of the last low clock. A nibble that differs from the previous low clock sets warning bit 0.
- R3: A cycle whose kept start code is not 0000 is never reported and sets no warning.
- R4: Cycle type 0000 (I/O read) and 0010 (I/O write) take a 4-nibble address. Types 0100 (memory read) and 0110 (memory write) take an 8-nibble address. The first address nibble lands in the highest position, and an I/O address is zero-extended to 32 bits. `txn_type` reports the type nibble.
- R5: A type nibble with bit 0 set, or with bits 3:2 equal to 11, sets warning bit 1 and the cycle is not reported. Any other type with bit 3 set is dropped without a warning.
- R6: The data byte arrives low nibble first. On a write it occupies the two clocks right after the address. On a read it occupies the two clocks right after the ready nibble.
- R7: Each turnaround lasts two clocks, and both must read 1111. A bad first turnaround sets warning bit 2 and a bad final turnaround sets warning bit 5. The cycle is still reported.
- R8: In the handshake, 0101 and 0110 are waits and 0000 is ready. Any other value except 1010 sets warning bit 3 and the handshake continues.
- R9: Handshake value 1010 sets warning bit 4 and drops the cycle without a report.
- R10: A low frame strobe seen outside the idle and start states abandons the current cycle, clears the warnings and starts a new start-code capture.
- R11: `txn_valid` pulses for exactly one clock, registered on the edge that samples the second final-turnaround nibble, with all result fields. Warning bits are never cleared while the frame strobe is high.
- R12: An active-low `rst_n` returns the monitor to idle and clears every output to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock, sampled on rising edges |
| rst_n | input | 1 | Active-low bus reset, asynchronous |
| frm_n | input | 1 | Active-low frame strobe |
| nib | input | 4 | Multiplexed nibble bus |
| txn_valid | output | 1 | One-clock pulse when a cycle completes |
| txn_start | output | 4 | Start code of the cycle |
| txn_type | output | 4 | Cycle type nibble |
| txn_addr | output | 32 | Assembled address |
| txn_data | output | 8 | Assembled data byte |
| txn_warn | output | 6 | Warning vector for the current or last cycle |

## Verification
The monitor has no parameters, so the bench builds it exactly as it would be used. Widths are fixed by the bus, and the 16-bit and 32-bit address paths both lie inside every build. The bench therefore gets its reach from the bus patterns it drives: held and changing start codes, waits of both kinds, reserved handshake and type values, a restart halfway through an address, and a reset halfway through a cycle. Every reported cycle is compared field by field against a queue of expected results.

// File: rtl/lpc_txn_monitor.sv
module lpc_txn_monitor (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        frm_n,
  input  logic [3:0]  nib,
  output logic        txn_valid,
  output logic [3:0]  txn_start,
  output logic [3:0]  txn_type,
  output logic [31:0] txn_addr,
  output logic [7:0]  txn_data,
  output logic [5:0]  txn_warn
);
  typedef enum logic [2:0] {
    S_IDLE, S_START, S_ADDR, S_DATA, S_TAR1, S_SYNC, S_TAR2
  } st_t;

  localparam int W_START = 0;
  localparam int W_TYPE  = 1;
  localparam int W_TAR1  = 2;
  localparam int W_SYNC  = 3;
  localparam int W_ERR   = 4;
  localparam int W_TAR2  = 5;

  st_t         st;
  logic [3:0]  start_q, type_q;
  logic [31:0] addr_q;
  logic [7:0]  data_q;
  logic [5:0]  warn_q;
  logic [2:0]  cnt;
  logic        wr_q, hi_q, valid_q;

  wire bad_type = nib[0] || (nib[3:2] == 2'b11);
  wire tar_ok   = (nib == 4'hF);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      start_q <= '0;
      type_q  <= '0;
      addr_q  <= '0;
      data_q  <= '0;
      warn_q  <= '0;
      cnt     <= '0;
      wr_q    <= 1'b0;
      hi_q    <= 1'b0;
      valid_q <= 1'b0;
    end else begin
      valid_q <= 1'b0;
      if (!frm_n && st != S_START) begin
        st      <= S_START;
        start_q <= nib;
        warn_q  <= '0;
      end else begin
        case (st)
          S_IDLE: ;
          S_START: begin
            if (!frm_n) begin
              if (nib != start_q) warn_q[W_START] <= 1'b1;
              start_q <= nib;
            end else if (start_q != 4'h0) begin
              st <= S_IDLE;
            end else if (bad_type) begin
              warn_q[W_TYPE] <= 1'b1;
              st <= S_IDLE;
            end else if (nib[3]) begin
              st <= S_IDLE;
            end else begin
              type_q <= nib;
              wr_q   <= nib[1];
              cnt    <= nib[2] ? 3'd7 : 3'd3;
              addr_q <= '0;
              data_q <= '0;
              hi_q   <= 1'b0;
              st     <= S_ADDR;
            end
          end
          S_ADDR: begin
            addr_q <= {addr_q[27:0], nib};
            if (cnt == 3'd0) st <= wr_q ? S_DATA : S_TAR1;
            else cnt <= cnt - 3'd1;
          end
          S_DATA: begin
            hi_q <= ~hi_q;
            if (!hi_q) data_q[3:0] <= nib;
            else begin
              data_q[7:4] <= nib;
              st <= wr_q ? S_TAR1 : S_TAR2;
            end
          end
          S_TAR1: begin
            if (!tar_ok) warn_q[W_TAR1] <= 1'b1;
            hi_q <= ~hi_q;
            if (hi_q) st <= S_SYNC;
          end
          S_SYNC: begin
            case (nib)
              4'h0: st <= wr_q ? S_TAR2 : S_DATA;
              4'h5, 4'h6: ;
              4'hA: begin
                warn_q[W_ERR] <= 1'b1;
                st <= S_IDLE;
              end
              default: warn_q[W_SYNC] <= 1'b1;
            endcase
          end
          S_TAR2: begin
            if (!tar_ok) warn_q[W_TAR2] <= 1'b1;
            hi_q <= ~hi_q;
            if (hi_q) begin
              valid_q <= 1'b1;
              st <= S_IDLE;
            end
          end
          default: st <= S_IDLE;
        endcase
      end
    end
  end

  assign txn_valid = valid_q;
  assign txn_start = start_q;
  assign txn_type  = type_q;
  assign txn_addr  = addr_q;
  assign txn_data  = data_q;
  assign txn_warn  = warn_q;
endmodule

module lpc_txn_monitor_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       frm_n,
  input logic [3:0] nib,
  input logic [2:0] state,
  input logic       txn_valid,
  input logic [3:0] txn_start,
  input logic [3:0] txn_type,
  input logic [5:0] txn_warn
);
  localparam logic [2:0] ST_SYNC = 3'd5;
  localparam logic [2:0] ST_TAR2 = 3'd6;

  // R11
  valid_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    txn_valid |=> !txn_valid);

  // R12
  reset_clear_chk: assert property (@(posedge clk)
    !rst_n |=> (!txn_valid && txn_warn == 6'd0));

  // R3 R4
  legal_report_chk: assert property (@(posedge clk) disable iff (!rst_n)
    txn_valid |-> (txn_start == 4'h0 && !txn_type[3] && !txn_type[0]));

  // R10
  frame_high_report_chk: assert property (@(posedge clk) disable iff (!rst_n)
    txn_valid |-> $past(frm_n));

  // R11
  warn_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(frm_n) && $past(rst_n)) |-> (($past(txn_warn) & ~txn_warn) == 6'd0));

  // R9
  sync_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_SYNC && frm_n && nib == 4'hA) |=> (!txn_valid && txn_warn[4]));

  // R7
  tar2_warn_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_TAR2 && frm_n && nib != 4'hF) |=> txn_warn[5]);
endmodule

bind lpc_txn_monitor lpc_txn_monitor_chk u_chk (
  .clk(clk), .rst_n(rst_n), .frm_n(frm_n), .nib(nib), .state(st),
  .txn_valid(txn_valid), .txn_start(txn_start), .txn_type(txn_type),
  .txn_warn(txn_warn)
);

// File: tb/lpc_txn_monitor_tb.sv
module lpc_txn_monitor_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        frm_n = 1'b1;
  logic [3:0]  nib = 4'hF;
  logic        txn_valid;
  logic [3:0]  txn_start, txn_type;
  logic [31:0] txn_addr;
  logic [7:0]  txn_data;
  logic [5:0]  txn_warn;

  int vecs = 0;
  int bad = 0;
  int pulses = 0;
  bit done = 0;

  typedef struct {
    logic [3:0]  ty;
    logic [31:0] ad;
    logic [7:0]  da;
    logic [5:0]  wn;
    string       tag;
  } exp_t;
  exp_t q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  lpc_txn_monitor u_dut (
    .clk(clk), .rst_n(rst_n), .frm_n(frm_n), .nib(nib),
    .txn_valid(txn_valid), .txn_start(txn_start), .txn_type(txn_type),
    .txn_addr(txn_addr), .txn_data(txn_data), .txn_warn(txn_warn)
  );

  task automatic check(input logic [31:0] act, input logic [31:0] exp, input string tag);
    vecs++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (txn_valid === 1'b1) begin
      pulses++;
      if (q.size() == 0) begin
        vecs++; bad++;
        $display("FAIL R3 R11: unexpected report addr actual %0h expected none", txn_addr);
      end else begin
        exp_t e;
        e = q.pop_front();
        check({28'd0, txn_start}, 32'd0,          {e.tag, " start"});
        check({28'd0, txn_type},  {28'd0, e.ty},  {e.tag, " type"});
        check(txn_addr,           e.ad,           {e.tag, " addr"});
        check({24'd0, txn_data},  {24'd0, e.da},  {e.tag, " data"});
        check({26'd0, txn_warn},  {26'd0, e.wn},  {e.tag, " warn"});
      end
    end
  end

  task automatic cyc(input logic f, input logic [3:0] n);
    frm_n = f;
    nib   = n;
    @(negedge clk);
  endtask

  task automatic run_txn(input logic [3:0] pre, input int hold, input logic [3:0] ct,
                         input logic [31:0] a, input logic [7:0] d, input int waits,
                         input logic [3:0] wc, input logic [3:0] t1, input logic [3:0] t2,
                         input logic [5:0] ew, input string tag);
    exp_t e;
    int nn;
    e.ty = ct; e.ad = a; e.da = d; e.wn = ew; e.tag = tag;
    q.push_back(e);
    for (int i = 1; i < hold; i++) cyc(1'b0, pre);
    cyc(1'b0, 4'h0);
    cyc(1'b1, ct);
    nn = ct[2] ? 8 : 4;
    for (int i = nn - 1; i >= 0; i--) cyc(1'b1, a[i*4 +: 4]);
    if (ct[1]) begin cyc(1'b1, d[3:0]); cyc(1'b1, d[7:4]); end
    cyc(1'b1, t1); cyc(1'b1, 4'hF);
    for (int i = 0; i < waits; i++) cyc(1'b1, wc);
    cyc(1'b1, 4'h0);
    if (!ct[1]) begin cyc(1'b1, d[3:0]); cyc(1'b1, d[7:4]); end
    cyc(1'b1, t2); cyc(1'b1, 4'hF);
    cyc(1'b1, 4'hF);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      bad++;
      $display("FAIL watchdog: actual hung expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vecs, bad);
      $finish;
    end
  end

  initial begin
    int p0;
    repeat (2) @(negedge clk);
    // R12 reset state
    check({31'd0, txn_valid}, 0, "R12 valid in reset");
    check(txn_addr, 0, "R12 addr in reset");
    check({26'd0, txn_warn}, 0, "R12 warn in reset");
    rst_n = 1'b1;
    // R1 idle ignores nibbles
    cyc(1'b1, 4'h0); cyc(1'b1, 4'h4); cyc(1'b1, 4'hA); cyc(1'b1, 4'h3);
    check(pulses, 0, "R1 idle pulses");
    check({26'd0, txn_warn}, 0, "R1 idle warn");

    run_txn(4'h0, 1, 4'h0, 32'h0000_1234, 8'h5A, 0, 4'h5, 4'hF, 4'hF, 6'd0, "R4 R6 io read");
    run_txn(4'h0, 1, 4'h2, 32'h0000_BEEF, 8'hC3, 2, 4'h5, 4'hF, 4'hF, 6'd0, "R6 R8 io write");
    run_txn(4'h0, 1, 4'h4, 32'hFFEE_1357, 8'h81, 3, 4'h6, 4'hF, 4'hF, 6'd0, "R4 R8 mem read");
    run_txn(4'h0, 3, 4'h6, 32'h0012_3456, 8'h7E, 0, 4'h5, 4'hF, 4'hF, 6'd0, "R2 R11 mem write");
    run_txn(4'hF, 2, 4'h4, 32'h89AB_CDEF, 8'h01, 0, 4'h5, 4'hF, 4'hF, 6'b000001, "R2 start change");
    run_txn(4'h0, 1, 4'h0, 32'h0000_00A5, 8'h3C, 0, 4'h5, 4'hE, 4'hF, 6'b000100, "R7 tar1");
    run_txn(4'h0, 1, 4'h6, 32'hCAFE_0042, 8'h99, 0, 4'h5, 4'hF, 4'h7, 6'b100000, "R7 tar2");
    run_txn(4'h0, 1, 4'h2, 32'h0000_0F0F, 8'hE1, 1, 4'h3, 4'hF, 4'hF, 6'b001000, "R8 reserved sync");

    // R9 handshake error
    p0 = pulses;
    cyc(1'b0, 4'h0); cyc(1'b1, 4'h4);
    for (int i = 0; i < 8; i++) cyc(1'b1, 4'h1);
    cyc(1'b1, 4'hF); cyc(1'b1, 4'hF); cyc(1'b1, 4'h5); cyc(1'b1, 4'hA);
    cyc(1'b1, 4'h0); cyc(1'b1, 4'h2); cyc(1'b1, 4'hF); cyc(1'b1, 4'hF); cyc(1'b1, 4'hF);
    check(pulses - p0, 0, "R9 no report");
    check({26'd0, txn_warn}, 32'h10, "R9 warn");

    // R5 reserved type
    cyc(1'b0, 4'h0); cyc(1'b1, 4'hC);
    for (int i = 0; i < 12; i++) cyc(1'b1, 4'hF);
    check(pulses - p0, 0, "R5 reserved no report");
    check({26'd0, txn_warn}, 32'h02, "R5 reserved warn");
    cyc(1'b0, 4'h0); cyc(1'b1, 4'h8);
    for (int i = 0; i < 12; i++) cyc(1'b1, 4'hF);
    check(pulses - p0, 0, "R5 dma no report");
    check({26'd0, txn_warn}, 0, "R5 dma warn");

    // R3 non-target start code
    cyc(1'b0, 4'hD); cyc(1'b1, 4'h4);
    for (int i = 0; i < 8; i++) cyc(1'b1, 4'h2);
    cyc(1'b1, 4'hF); cyc(1'b1, 4'hF); cyc(1'b1, 4'h0);
    cyc(1'b1, 4'h1); cyc(1'b1, 4'h2); cyc(1'b1, 4'hF); cyc(1'b1, 4'hF); cyc(1'b1, 4'hF);
    check(pulses - p0, 0, "R3 no report");
    check({26'd0, txn_warn}, 0, "R3 warn");

    // R10 restart mid-address after a start warning
    cyc(1'b0, 4'h7); cyc(1'b0, 4'h0); cyc(1'b1, 4'h4);
    cyc(1'b1, 4'h9); cyc(1'b1, 4'h9); cyc(1'b1, 4'h9);
    check({26'd0, txn_warn}, 32'h01, "R10 warn before restart");
    run_txn(4'h0, 1, 4'h0, 32'h0000_4321, 8'h6B, 0, 4'h5, 4'hF, 4'hF, 6'd0, "R10 restart");

    // R12 reset mid-cycle
    p0 = pulses;
    cyc(1'b0, 4'h0); cyc(1'b1, 4'h0); cyc(1'b1, 4'h1); cyc(1'b1, 4'h2);
    rst_n = 1'b0;
    cyc(1'b1, 4'h3);
    check({31'd0, txn_valid}, 0, "R12 valid mid reset");
    check(txn_addr, 0, "R12 addr mid reset");
    rst_n = 1'b1;
    cyc(1'b1, 4'h4); cyc(1'b1, 4'hF); cyc(1'b1, 4'hF); cyc(1'b1, 4'h0);
    cyc(1'b1, 4'h1); cyc(1'b1, 4'h2); cyc(1'b1, 4'hF); cyc(1'b1, 4'hF); cyc(1'b1, 4'hF);
    check(pulses - p0, 0, "R12 no report after reset");

    check(q.size(), 0, "R11 all expected reports seen");
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vecs, bad);
    $finish;
  end
endmodule